// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Generator

This block takes a raster-scanned stream of pixels, one per clock while the input strobe is high, and turns it into a complete 3x3 neighbourhood every clock once enough rows have passed. A filter stage placed after it (smoothing, gradient or any other 3x3 kernel) reads all nine pixels at once and produces one result per accepted pixel.

The two earlier image rows are held in two circular line stores. Each store is a simple dual-port RAM with `IMG_W-3` entries that is read and written in the same clock. The nine window pixels sit in three rows of three registers. The read pointer always runs one slot ahead of the write pointer. As a result, every pixel leaves a store exactly `IMG_W-3` accepted clocks after it was written, and the full window is ready after a fixed `2*IMG_W+3` accepted pixels.

A frame-start pulse returns the pointers, the window registers, the fill counter and the valid strobe to their initial state. When the input strobe is low, the whole pipeline freezes, so stalls in the middle of a row leave the row history intact.

Top module: `lineWindow3x3`

## Requirements
- R1: A pixel is accepted on every rising clock edge where `pixValid` is high and `frameStart` is low. Each accepted pixel moves the whole pipeline forward by exactly one position.
- R2: Let the n-th accepted pixel of the frame be numbered n, counting from 1. After the edge that accepts pixel n, and once the window is full:
  - `win7`, `win8`, `win9` hold pixels n-2, n-1, n.
  - `win4`, `win5`, `win6` hold pixels n-IMG_W-2, n-IMG_W-1, n-IMG_W.
  - `win1`, `win2`, `win3` hold pixels n-2*IMG_W-2, n-2*IMG_W-1, n-2*IMG_W.
  - So `win1..win3` is the oldest row and `win7..win9` the newest, each ordered left to right, and `win9` is the latest pixel.
- R3: The row history is kept in exactly two line stores of `IMG_W-3` entries each. Each store does one read and one write, on separate ports, for every accepted pixel.
- R4: The store read and write addresses each advance by one per accepted pixel, and wrap to zero after `IMG_W-4`.
- R5: The read address always equals the write address plus one, modulo `IMG_W-3`, so the two never collide.
- R6: `winValid` first goes high in the cycle after the (2*IMG_W+3)-th accepted pixel of a frame. It is never high before that.
- R7: A clock edge with `frameStart` high does the following:
  - Returns both addresses to their initial values (write 0, read 1).
  - Clears the fill count.
  - Clears all nine window outputs to zero.
  - Drives `winValid` low.
  - Discards any pixel presented in that same cycle.
- R8: On an edge with `pixValid` low (and no frame start), the following hold their values: the nine window outputs, both addresses and the fill count. `winValid` is low in the following cycle.
- R9: Once the window is full, `winValid` is high in the cycle following every accepted pixel. This gives one window per input pixel.
- R10: Asserting `rst_n` low returns the block to the same state as a frame start, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Synchronous restart of the row history |
| pixValid | input | 1 | Input pixel strobe |
| pixIn | input | PIX_W | Input pixel |
| win1 | output | PIX_W | Oldest row, left |
| win2 | output | PIX_W | Oldest row, centre |
| win3 | output | PIX_W | Oldest row, right |
| win4 | output | PIX_W | Middle row, left |
| win5 | output | PIX_W | Middle row, centre |
| win6 | output | PIX_W | Middle row, right |
| win7 | output | PIX_W | Newest row, left |
| win8 | output | PIX_W | Newest row, centre |
| win9 | output | PIX_W | Newest row, right (latest pixel) |
| winValid | output | 1 | A fresh complete window is presented |

## Verification
The bench builds the block with `IMG_W=8` and `PIX_W=8`. This gives line stores of five entries and a fill point at the nineteenth pixel. As a result, frames of a few hundred pixels wrap the store pointers dozens of times and cross the fill boundary many times per run. The narrow width also puts every window position, including the exact first-valid cycle, stalls inside the first rows and frame restarts shortly after fill, within a few thousand clocks.

// File: rtl/winGenPkg.sv
package winGenPkg;

  // Strobes issued by the sequencer to the window datapath
  typedef struct packed {
    logic clear;   // restart the row history
    logic shift;   // accept one pixel and advance everything
  } winStrobes_t;

endpackage

// File: rtl/winLineBuf.sv
module winLineBuf #(
  parameter int DEPTH  = 317,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port and one registered read port, both active in the same clock
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

  AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && rdEn) |-> (wrAddr != rdAddr)); // R5

  AST_PORTS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn == rdEn); // R3

endmodule

// File: rtl/winCtrl.sv
module winCtrl
  import winGenPkg::*;
#(
  parameter int IMG_W   = 320,
  localparam int LB_LEN = IMG_W - 3,
  localparam int AW     = $clog2(LB_LEN),
  localparam int FILL   = 2 * IMG_W + 3,
  localparam int CW     = $clog2(FILL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frameStart,
  input  logic          pixValid,
  output winStrobes_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          winValid
);

  logic [CW-1:0] fillCnt;

  always_comb begin
    stb.clear = frameStart;
    stb.shift = pixValid && !frameStart;
  end

  // Write and read pointers are separate counters; the read one starts a slot ahead
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrAddr <= '0;
      rdAddr <= AW'(1);
    end else if (stb.clear) begin
      wrAddr <= '0;
      rdAddr <= AW'(1);
    end else if (stb.shift) begin
      wrAddr <= (wrAddr == AW'(LB_LEN - 1)) ? '0 : wrAddr + AW'(1);
      rdAddr <= (rdAddr == AW'(LB_LEN - 1)) ? '0 : rdAddr + AW'(1);
    end
  end

  // Saturating fill counter and the per-pixel window strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillCnt  <= '0;
      winValid <= 1'b0;
    end else if (stb.clear) begin
      fillCnt  <= '0;
      winValid <= 1'b0;
    end else begin
      winValid <= 1'b0;
      if (stb.shift) begin
        if (fillCnt != CW'(FILL)) fillCnt <= fillCnt + CW'(1);
        winValid <= (fillCnt >= CW'(FILL - 1));
      end
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAddr < AW'(LB_LEN)) && (rdAddr < AW'(LB_LEN))); // R4

  AST_ADDR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    rdAddr == ((wrAddr == AW'(LB_LEN - 1)) ? AW'(0) : wrAddr + AW'(1))); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shift |=> wrAddr == (($past(wrAddr) == AW'(LB_LEN - 1)) ? AW'(0) : $past(wrAddr) + AW'(1))); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pixValid && !frameStart) |=> ($stable(wrAddr) && $stable(rdAddr) && $stable(fillCnt) && !winValid)); // R8

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (wrAddr == '0 && fillCnt == '0 && !winValid)); // R7

  AST_VALID_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    winValid |-> fillCnt == CW'(FILL)); // R6

endmodule

// File: rtl/winData.sv
module winData
  import winGenPkg::*;
#(
  parameter int IMG_W   = 320,
  parameter int PIX_W   = 8,
  localparam int LB_LEN = IMG_W - 3,
  localparam int AW     = $clog2(LB_LEN),
  localparam int ROWS   = 3,
  localparam int COLS   = 3,
  localparam int NBUF   = ROWS - 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  winStrobes_t                     stb,
  input  logic [AW-1:0]                   wrAddr,
  input  logic [AW-1:0]                   rdAddr,
  input  logic [PIX_W-1:0]                pixIn,
  output logic [ROWS*COLS-1:0][PIX_W-1:0] winFlat
);

  // rowReg[r][c]: r=0 oldest row, c=2 rightmost (latest) column
  logic [ROWS-1:0][COLS-1:0][PIX_W-1:0] rowReg;
  logic [ROWS-1:0][PIX_W-1:0]           feed;
  logic [NBUF-1:0][PIX_W-1:0]           lbWr;
  logic [NBUF-1:0][PIX_W-1:0]           lbRd;

  // Store b takes the left pixel of row ROWS-1-b and feeds the row above it
  always_comb begin
    feed[ROWS-1] = pixIn;
    for (int b = 0; b < NBUF; b++) begin
      lbWr[b]            = rowReg[ROWS-1-b][0];
      feed[ROWS-2-b]     = lbRd[b];
    end
  end

  generate
    for (genvar b = 0; b < NBUF; b++) begin : gLineBuf
      winLineBuf #(
        .DEPTH (LB_LEN),
        .DATA_W(PIX_W)
      ) lineBuf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wrEn  (stb.shift),
        .wrAddr(wrAddr),
        .wrData(lbWr[b]),
        .rdEn  (stb.shift),
        .rdAddr(rdAddr),
        .rdData(lbRd[b])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg <= '0;
    end else if (stb.clear) begin
      rowReg <= '0;
    end else if (stb.shift) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS - 1; c++) rowReg[r][c] <= rowReg[r][c+1];
        rowReg[r][COLS-1] <= feed[r];
      end
    end
  end

  generate
    for (genvar r = 0; r < ROWS; r++) begin : gRowOut
      for (genvar c = 0; c < COLS; c++) begin : gColOut
        assign winFlat[r*COLS + c] = rowReg[r][c];
      end
    end
  endgenerate

  AST_ROW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shift |=> (rowReg[ROWS-1][COLS-2] == $past(rowReg[ROWS-1][COLS-1]) &&
                   rowReg[ROWS-1][COLS-1] == $past(pixIn))); // R2

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.shift && !stb.clear) |=> $stable(winFlat)); // R8

  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> winFlat == '0); // R7

endmodule

// File: rtl/lineWindow3x3.sv
module lineWindow3x3
  import winGenPkg::*;
#(
  parameter int IMG_W   = 320,
  parameter int PIX_W   = 8,
  localparam int LB_LEN = IMG_W - 3,
  localparam int AW     = $clog2(LB_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] win1,
  output logic [PIX_W-1:0] win2,
  output logic [PIX_W-1:0] win3,
  output logic [PIX_W-1:0] win4,
  output logic [PIX_W-1:0] win5,
  output logic [PIX_W-1:0] win6,
  output logic [PIX_W-1:0] win7,
  output logic [PIX_W-1:0] win8,
  output logic [PIX_W-1:0] win9,
  output logic             winValid
);

  winStrobes_t          stb;
  logic [AW-1:0]        wrAddr;
  logic [AW-1:0]        rdAddr;
  logic [8:0][PIX_W-1:0] winFlat;

  winCtrl #(.IMG_W(IMG_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frameStart(frameStart),
    .pixValid  (pixValid),
    .stb       (stb),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .winValid  (winValid)
  );

  winData #(.IMG_W(IMG_W), .PIX_W(PIX_W)) data_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .pixIn  (pixIn),
    .winFlat(winFlat)
  );

  assign win1 = winFlat[0];
  assign win2 = winFlat[1];
  assign win3 = winFlat[2];
  assign win4 = winFlat[3];
  assign win5 = winFlat[4];
  assign win6 = winFlat[5];
  assign win7 = winFlat[6];
  assign win8 = winFlat[7];
  assign win9 = winFlat[8];

endmodule

// File: tb/lineWindow3x3_tb_top.sv
`timescale 1ns/1ps
module lineWindow3x3_tb_top;

  localparam int IMG_W = 8;
  localparam int PIX_W = 8;
  localparam int FILL  = 2 * IMG_W + 3;
  localparam int HMAX  = 4096;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frameStart = 1'b0;
  logic             pixValid = 1'b0;
  logic [PIX_W-1:0] pixIn = '0;
  logic [PIX_W-1:0] win1, win2, win3, win4, win5, win6, win7, win8, win9;
  logic             winValid;
  logic [PIX_W-1:0] gotWin [9];

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit acc = 0;
  bit done = 0;
  string zeroTag = "R10";
  logic [PIX_W-1:0] hist [HMAX];

  always #2.5 clk = ~clk;

  lineWindow3x3 #(.IMG_W(IMG_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .pixValid(pixValid),
    .pixIn(pixIn), .win1(win1), .win2(win2), .win3(win3), .win4(win4),
    .win5(win5), .win6(win6), .win7(win7), .win8(win8), .win9(win9),
    .winValid(winValid)
  );

  assign gotWin[0] = win1; assign gotWin[1] = win2; assign gotWin[2] = win3;
  assign gotWin[3] = win4; assign gotWin[4] = win5; assign gotWin[5] = win6;
  assign gotWin[6] = win7; assign gotWin[7] = win8; assign gotWin[8] = win9;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d (pixel count %0d)", tag, got, exp, n);
    end
  endtask

  // Expected pixel at window slot k after n accepted pixels (R2 layout)
  function automatic int expSlot(input int k, input int cnt);
    int r = k / 3;
    int c = k % 3;
    return int'(hist[cnt - (2 - r) * IMG_W - (2 - c)]);
  endfunction

  task automatic checkOut(input bit stall);
    bit expV = acc && (n >= FILL);
    if (n == FILL && acc)      chk("R6 first window", int'(winValid), 1);
    else if (n == FILL - 1 && acc) chk("R6 one short", int'(winValid), 0);
    else if (stall)            chk("R8 stall strobe", int'(winValid), 0);
    else                       chk("R1 R9 strobe", int'(winValid), int'(expV));
    if (n >= FILL) begin
      for (int k = 0; k < 9; k++)
        chk(stall ? "R8 held window" : "R2 R3 R4 R5 window", int'(gotWin[k]), expSlot(k, n));
    end else if (n == 0) begin
      for (int k = 0; k < 9; k++) chk(zeroTag, int'(gotWin[k]), 0);
    end
  endtask

  task automatic cycle(input bit v, input logic [PIX_W-1:0] p, input bit fs);
    pixValid = v; pixIn = p; frameStart = fs;
    @(posedge clk);
    if (fs) begin n = 0; acc = 0; zeroTag = "R7 cleared"; end
    else if (v) begin n++; hist[n] = p; acc = 1; end
    else acc = 0;
    @(negedge clk);
    checkOut(!v && !fs);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; pixValid = 1'b0; frameStart = 1'b0;
    #1;
    n = 0; acc = 0; zeroTag = "R10 reset";
    chk("R10 reset strobe", int'(winValid), 0);
    for (int k = 0; k < 9; k++) chk("R10 reset window", int'(gotWin[k]), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic randFrame(input int len, input int stallPct);
    cycle(1'b0, '0, 1'b1);
    for (int i = 0; i < len; i++) begin
      while (($urandom % 100) < stallPct) cycle(1'b0, PIX_W'($urandom), 1'b0);
      cycle(1'b1, PIX_W'($urandom), 1'b0);
    end
  endtask

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd24680);
    doReset();

    // Directed: continuous ramp, crossing the fill point exactly (R6, R9)
    cycle(1'b0, '0, 1'b1);
    for (int i = 1; i <= 3 * IMG_W + 5; i++) cycle(1'b1, PIX_W'(i * 7), 1'b0);

    // Directed: frame start together with a valid pixel discards it (R7)
    cycle(1'b1, 8'hEE, 1'b1);
    for (int i = 1; i <= FILL + 4; i++) cycle(1'b1, PIX_W'(255 - i), 1'b0);

    // Directed: stalls inside the first rows and just before/after fill (R8)
    cycle(1'b0, '0, 1'b1);
    for (int i = 1; i <= FILL + 6; i++) begin
      cycle(1'b1, PIX_W'(i + 100), 1'b0);
      if (i == 3 || i == IMG_W || i == FILL - 1 || i == FILL) begin
        cycle(1'b0, 8'h55, 1'b0);
        cycle(1'b0, 8'hAA, 1'b0);
      end
    end

    // Restart shortly after fill, then a random frame with many pointer wraps
    randFrame(FILL + 2, 0);
    randFrame(300, 30);

    // Asynchronous reset mid-stream, then a fresh frame (R10)
    doReset();
    randFrame(200, 10);
    randFrame(150, 50);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule